// File: doc/BRIEF.md
# Crate Status Serial Link

This block trades a seven-bit health word between two neighbouring equipment crates over a pair of one-way asynchronous serial lines. On the outgoing side it sends the local health flags without pause: watchdog good, temperature alarm, processor status, processor run, the two supply-good flags and processor failure. Each frame takes a fresh copy of those flags at its first bit. On the incoming side it oversamples the neighbour's line, rebuilds each frame and keeps the most recent word that arrived with a good stop bit.

Both words are shown together in one 16-bit read-only value. The low byte is the word last received and the high byte is the word now being sent. If the neighbour stays silent for too long, the block raises a link-lost flag and replaces the received word with a pessimistic all-zero value. The bit rate is set by two parameters, the system clock frequency and the baud rate. From them the block derives an oversampling tick at sixteen ticks per bit.

Top module: `crate_status_link`

## Requirements
- R1: A frame on `ser_tx_o` is one start bit at 0, then 7 data bits with the least significant bit first, then one stop bit at 1. Every bit lasts 16 × TICK_DIV clock cycles, where TICK_DIV = CLK_HZ / (BAUD × 16).
- R2: Frames are sent back to back, so each start bit follows the previous stop bit at once (9 bit times from start to start). The local status is captured at the start bit of each frame, so a change is carried no later than the second frame that starts after it.
- R3: Data bit positions in both directions: bit0 watchdog good, bit1 temperature alarm (active low), bit2 processor status (active low), bit3 processor run (active low), bit4 +5 V good, bit5 ±12 V good, bit6 processor failure (active low).
- R4: `stat_reg_o[14:8]` shows the word in the frame now on `ser_tx_o`, and `stat_reg_o[15]` reads 0.
- R5: After a frame with a good stop bit, `stat_reg_o[6:0]` shows its data bits and `stat_reg_o[7]` reads 0.
- R6: A low pulse on `ser_rx_i` that lasts less than half a bit is rejected when the start bit is checked at mid-bit. The received byte keeps its value.
- R7: A frame whose stop bit is sampled low is discarded. The received byte keeps its value, and the frame does not restart the silence timer.
- R8: If no good frame arrives within 8 frame times (8 × 9 × 16 ticks) of the last good one, `link_lost_o` goes to 1 and `stat_reg_o[7:0]` reads 0x00 (watchdog not good).
- R9: A good frame clears `link_lost_o` and shows its data in the low byte.
- R10: While and after reset, `ser_tx_o` is 1, `stat_reg_o` is 0x0000 and `link_lost_o` is 1, until the first frame starts or arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wdog_ok_i | input | 1 | Local watchdog good |
| temp_bad_n_i | input | 1 | Local temperature alarm, active low |
| cpu_stat_n_i | input | 1 | Local processor status, active low |
| cpu_run_n_i | input | 1 | Local processor run, active low |
| sup5_ok_i | input | 1 | Local +5 V good |
| sup12_ok_i | input | 1 | Local ±12 V good |
| cpu_fail_n_i | input | 1 | Local processor failure, active low |
| ser_rx_i | input | 1 | Serial line from the neighbour |
| ser_tx_o | output | 1 | Serial line to the neighbour |
| stat_reg_o | output | 16 | {0, word being sent, 0, word received} |
| link_lost_o | output | 1 | No good frame within 8 frame times |

## Verification
The hardest condition to reach from the ports is a link that is busy but still lost. Frames keep arriving with bad stop bits, so the receiver stays active, yet the silence timer must still expire. The bench creates this by sending a good frame and then a train of nine frames with low stop bits, which together last longer than the timeout, and it checks that the flag rises anyway. The bench also checks the timeout from both sides: it samples the flag well before and just after eight frame times of true silence.

// File: rtl/stlink_pkg.sv
package stlink_pkg;

    localparam int OVS         = 16;
    localparam int DATA_BITS   = 7;
    localparam int FRAME_BITS  = DATA_BITS + 2;
    localparam int LOST_FRAMES = 8;

    // Field order fixes the bit position on the line: wdog_ok is bit 0.
    typedef struct packed {
        logic cpu_fail_n;
        logic sup12_ok;
        logic sup5_ok;
        logic cpu_run_n;
        logic cpu_stat_n;
        logic temp_bad_n;
        logic wdog_ok;
    } crate_stat_t;

    localparam crate_stat_t SAFE_STAT = '0;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic int tick_div(input int clk_hz, input int baud);
        int d;
        d = clk_hz / (baud * OVS);
        return (d < 2) ? 2 : d;
    endfunction

endpackage

// File: rtl/stlink_tick.sv
module stlink_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt == CW'(DIV - 1));
            if (cnt == CW'(DIV - 1)) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end

    // R1: ticks are isolated pulses, so a bit lasts OVS*DIV cycles
    tick_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/stlink_tx.sv
module stlink_tx
    import stlink_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  crate_stat_t stat_i,
    output logic        txd_o,
    output crate_stat_t word_o
);
    localparam int SUB_W = $clog2(OVS);

    logic             busy;
    logic [SUB_W-1:0] sub;
    logic [3:0]       idx;
    crate_stat_t      word;
    logic [2:0]       dsel;
    logic             bit_end;
    logic             frame_end;

    assign bit_end   = tick_i && (sub == SUB_W'(OVS - 1));
    assign frame_end = bit_end && (idx == 4'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sub  <= '0;
            idx  <= '0;
            word <= SAFE_STAT;
        end else if (!busy || frame_end) begin
            busy <= 1'b1;
            word <= stat_i;
            idx  <= '0;
            sub  <= '0;
        end else if (tick_i) begin
            sub <= sub + 1'b1;
            if (bit_end) idx <= idx + 1'b1;
        end
    end

    assign dsel = 3'(idx - 4'd1);

    always_comb begin
        if (!busy)                            txd_o = 1'b1;
        else if (idx == 4'd0)                 txd_o = 1'b0;
        else if (idx == 4'(FRAME_BITS - 1))   txd_o = 1'b1;
        else                                  txd_o = word[dsel];
    end

    assign word_o = word;

    // R2: the captured word holds for a whole frame
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_end) |=> $stable(word_o));

    // R2: the next start bit follows a stop bit at once
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !txd_o);

endmodule

// File: rtl/stlink_rx.sv
module stlink_rx
    import stlink_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        rxd_i,
    output logic        valid_o,
    output logic        ferr_o,
    output crate_stat_t data_o
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] HALF = SUB_W'(OVS / 2 - 1);
    localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

    logic [1:0]           sync;
    logic                 rxs;
    rx_state_e            st;
    logic [SUB_W-1:0]     sub;
    logic [2:0]           idx;
    logic [DATA_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd_i};
    end
    assign rxs = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            sub     <= '0;
            idx     <= '0;
            sh      <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            if (tick_i) begin
                unique case (st)
                    RX_IDLE: begin
                        if (!rxs) begin
                            st  <= RX_START;
                            sub <= '0;
                        end
                    end
                    RX_START: begin
                        if (sub == HALF) begin
                            sub <= '0;
                            idx <= '0;
                            st  <= rxs ? RX_IDLE : RX_DATA;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (sub == LAST) begin
                            sub <= '0;
                            sh  <= {rxs, sh[DATA_BITS-1:1]};
                            if (idx == 3'(DATA_BITS - 1)) st <= RX_STOP;
                            else                          idx <= idx + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (sub == LAST) begin
                            sub <= '0;
                            st  <= RX_IDLE;
                            if (rxs) valid_o <= 1'b1;
                            else     ferr_o  <= 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    assign data_o = crate_stat_t'(sh);

    // R5: one acceptance pulse per frame
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: a frame with a low stop bit is never accepted
    bad_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ferr_o |-> !valid_o);

    // R6: a rejected start returns to idle without accepting anything
    start_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RX_START && tick_i && sub == HALF && rxs) |=> (st == RX_IDLE && !valid_o));

endmodule

// File: rtl/stlink_watch.sv
module stlink_watch
    import stlink_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        valid_i,
    input  crate_stat_t data_i,
    output logic        lost_o,
    output crate_stat_t byte_o
);
    localparam int LIMIT = LOST_FRAMES * FRAME_BITS * OVS;
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    crate_stat_t   hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lost_o <= 1'b1;
            hold   <= SAFE_STAT;
        end else if (valid_i) begin
            cnt    <= '0;
            lost_o <= 1'b0;
            hold   <= data_i;
        end else if (tick_i && !lost_o) begin
            if (cnt == CW'(LIMIT - 1)) begin
                cnt    <= '0;
                lost_o <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign byte_o = lost_o ? SAFE_STAT : hold;

    // R9: a good frame clears the lost flag
    recover_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> !lost_o);

    // R8: the flag only rises when no frame is accepted
    lost_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_o) |-> $past(!valid_i));

    // R8: once lost, it stays lost until a good frame
    lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lost_o && !valid_i) |=> lost_o);

endmodule

// File: rtl/crate_status_link.sv
module crate_status_link
    import stlink_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int BAUD   = 9600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wdog_ok_i,
    input  logic        temp_bad_n_i,
    input  logic        cpu_stat_n_i,
    input  logic        cpu_run_n_i,
    input  logic        sup5_ok_i,
    input  logic        sup12_ok_i,
    input  logic        cpu_fail_n_i,
    input  logic        ser_rx_i,
    output logic        ser_tx_o,
    output logic [15:0] stat_reg_o,
    output logic        link_lost_o
);
    localparam int TICK_DIV = tick_div(CLK_HZ, BAUD);

    logic        tick;
    crate_stat_t local_stat;
    crate_stat_t tx_word;
    crate_stat_t rx_data;
    crate_stat_t rx_byte;
    logic        rx_valid;
    logic        rx_ferr;

    always_comb begin
        local_stat.wdog_ok    = wdog_ok_i;
        local_stat.temp_bad_n = temp_bad_n_i;
        local_stat.cpu_stat_n = cpu_stat_n_i;
        local_stat.cpu_run_n  = cpu_run_n_i;
        local_stat.sup5_ok    = sup5_ok_i;
        local_stat.sup12_ok   = sup12_ok_i;
        local_stat.cpu_fail_n = cpu_fail_n_i;
    end

    stlink_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    stlink_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .stat_i (local_stat),
        .txd_o  (ser_tx_o),
        .word_o (tx_word)
    );

    stlink_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .rxd_i   (ser_rx_i),
        .valid_o (rx_valid),
        .ferr_o  (rx_ferr),
        .data_o  (rx_data)
    );

    stlink_watch u_watch (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .valid_i (rx_valid && !rx_ferr),
        .data_i  (rx_data),
        .lost_o  (link_lost_o),
        .byte_o  (rx_byte)
    );

    assign stat_reg_o = {1'b0, tx_word, 1'b0, rx_byte};

    // R8: a lost link always shows the watchdog as not good
    lost_safe_chk: assert property (@(posedge clk) disable iff (rst)
        link_lost_o |-> !stat_reg_o[0]);

endmodule

// File: tb/sim_crate_status_link.sv
module sim_crate_status_link;

    localparam int CLK_HZ = 125_000_000;
    localparam int BAUD   = 1_953_125;   // 4 clocks per tick, 64 per bit
    localparam int BT     = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wdog_ok, temp_bad_n, cpu_stat_n, cpu_run_n, sup5_ok, sup12_ok, cpu_fail_n;
    logic        ser_rx = 1'b1;
    logic        ser_tx;
    logic [15:0] stat_reg;
    logic        link_lost;

    always #4 clk = ~clk;

    crate_status_link #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
        .clk          (clk),
        .rst          (rst),
        .wdog_ok_i    (wdog_ok),
        .temp_bad_n_i (temp_bad_n),
        .cpu_stat_n_i (cpu_stat_n),
        .cpu_run_n_i  (cpu_run_n),
        .sup5_ok_i    (sup5_ok),
        .sup12_ok_i   (sup12_ok),
        .cpu_fail_n_i (cpu_fail_n),
        .ser_rx_i     (ser_rx),
        .ser_tx_o     (ser_tx),
        .stat_reg_o   (stat_reg),
        .link_lost_o  (link_lost)
    );

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R3 positions: bit0 wdog, 1 temp_n, 2 stat_n, 3 run_n, 4 +5V, 5 12V, 6 fail_n
    task automatic set_local(input logic [6:0] v);
        wdog_ok    = v[0];
        temp_bad_n = v[1];
        cpu_stat_n = v[2];
        cpu_run_n  = v[3];
        sup5_ok    = v[4];
        sup12_ok   = v[5];
        cpu_fail_n = v[6];
    endtask

    // scoreboard for the receive side
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       ev_chk;

    always begin
        logic [7:0] e;
        string      t;
        @(ev_chk);
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(stat_reg[7:0] == e, t, int'(stat_reg[7:0]), int'(e));
    end

    task automatic send_frame(input logic [6:0] d, input bit stop_ok,
                              input bit do_chk, input logic [7:0] e, input string tag);
        ser_rx = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            ser_rx = d[i];
            repeat (BT) @(negedge clk);
        end
        ser_rx = stop_ok;
        repeat (BT) @(negedge clk);
        ser_rx = 1'b1;
        if (do_chk) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
            -> ev_chk;
            repeat (2) @(negedge clk);
        end
    endtask

    // transmit-side decoder
    longint     cyc = 0;
    logic [6:0] tx_q[$];
    int         gap_last = 0;
    int         stop_err = 0;

    always @(posedge clk) cyc++;

    initial begin
        longint     last_start;
        longint     s;
        logic [6:0] w;
        logic       ok;
        last_start = -1;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (ser_tx == 1'b0) begin
                s = cyc;
                repeat (BT / 2) @(negedge clk);
                ok = (ser_tx == 1'b0);
                for (int i = 0; i < 7; i++) begin
                    repeat (BT) @(negedge clk);
                    w[i] = ser_tx;
                end
                repeat (BT) @(negedge clk);
                ok = ok && ser_tx;
                if (!ok) stop_err++;
                if (last_start >= 0) gap_last = int'(s - last_start);
                last_start = s;
                tx_q.push_back(w);
            end
        end
    end

    task automatic check_tx(input logic [6:0] v, input string tag);
        set_local(v);
        tx_q.delete();
        wait (tx_q.size() >= 2);
        @(negedge clk);
        chk(tx_q[1] == v, tag, int'(tx_q[1]), int'(v));
        chk(stat_reg[15:8] == {1'b0, v}, "R4 tx mirror", int'(stat_reg[15:8]), int'({1'b0, v}));
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        set_local(7'h00);
        repeat (3) @(negedge clk);
        // R10 during reset
        chk(ser_tx == 1'b1, "R10 tx idle in reset", int'(ser_tx), 1);
        chk(stat_reg == 16'h0000, "R10 reg in reset", int'(stat_reg), 0);
        chk(link_lost == 1'b1, "R10 lost in reset", int'(link_lost), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(link_lost == 1'b1 && stat_reg[7:0] == 8'h00, "R10 after reset",
            int'({link_lost, stat_reg[7:0]}), 16'h100);

        // R1 R3 transmit format and bit order
        check_tx(7'h01, "R3 watchdog in bit0");
        check_tx(7'h40, "R3 fail_n in bit6");
        check_tx(7'h56, "R1 tx pattern");
        check_tx(7'h29, "R1 tx pattern two");
        chk(gap_last == 9 * BT, "R2 back-to-back frames", gap_last, 9 * BT);

        // R5 R9 receive
        send_frame(7'h5A, 1'b1, 1'b1, 8'h5A, "R9 first good frame");
        chk(link_lost == 1'b0, "R9 lost cleared", int'(link_lost), 0);
        send_frame(7'h25, 1'b1, 1'b1, 8'h25, "R5 second frame");

        // R6 glitch shorter than half a bit
        ser_rx = 1'b0;
        repeat (20) @(negedge clk);
        ser_rx = 1'b1;
        repeat (3 * BT) @(negedge clk);
        exp_q.push_back(8'h25);
        tag_q.push_back("R6 glitch rejected");
        -> ev_chk;
        repeat (2) @(negedge clk);

        // R7 bad stop bit
        send_frame(7'h7F, 1'b0, 1'b1, 8'h25, "R7 bad stop discarded");
        repeat (BT) @(negedge clk);

        // R8 timeout from both sides
        send_frame(7'h33, 1'b1, 1'b1, 8'h33, "R5 frame before silence");
        repeat (4300) @(negedge clk);
        chk(link_lost == 1'b0 && stat_reg[7:0] == 8'h33, "R8 not lost early",
            int'({link_lost, stat_reg[7:0]}), 16'h033);
        repeat (500) @(negedge clk);
        chk(link_lost == 1'b1, "R8 lost after 8 frames", int'(link_lost), 1);
        chk(stat_reg[7:0] == 8'h00, "R8 safe byte", int'(stat_reg[7:0]), 0);

        // R9 recovery
        send_frame(7'h11, 1'b1, 1'b1, 8'h11, "R9 recovery frame");
        chk(link_lost == 1'b0, "R9 lost cleared again", int'(link_lost), 0);

        // R7 R8 bad frames keep arriving but do not refresh the link
        for (int k = 0; k < 9; k++) begin
            send_frame(7'h11, 1'b0, 1'b0, 8'h00, "");
            repeat (BT) @(negedge clk);
        end
        chk(link_lost == 1'b1, "R8 lost despite bad frames", int'(link_lost), 1);
        chk(stat_reg[7:0] == 8'h00, "R7 bad frames ignored", int'(stat_reg[7:0]), 0);

        chk(stop_err == 0, "R1 tx start/stop levels", stop_err, 0);
        chk(stat_reg[15] == 1'b0 && stat_reg[7] == 1'b0, "R4 R5 pad bits",
            int'({stat_reg[15], stat_reg[7]}), 0);
        finish_run();
    end

endmodule